// File: doc/BRIEF.md
# Dual-Clock Two-Port RAM with Per-Port Read Latency

This block is a two-port static RAM. Each port has its own clock, reset, address, write data and controls, and both ports can reach every word at any time. A port samples its controls on the rising edge of its own clock. Two enables qualify each access: an active-low `cs_n` and an active-high `cs`. A `rd_wr` line picks a read (1) or a write (0). An asynchronous `oe_n` gates the read output.

Read data leaves on a dedicated output bus with a drive-enable flag `rvalid`, which takes the place of a tri-state pin. A static `pipe` pin sets the read latency of each port. With `pipe` = 0 (flow-through), read data follows the sampling edge within the same cycle. With `pipe` = 1 (pipelined), the data and the registered select state take one more register stage. Addresses arrive already resolved. The word count is 2^`ADDR_W` and can be raised up to 64K words.

Top module: `dpram_dual_clk`

## Requirements
- R1: After reset, each port holds `rvalid` = 0 and `rdata` = 0 until it performs a selected read. Reset does not alter the stored words.
- R2: A port is selected when `cs_n` = 0 and `cs` = 1. A selected edge with `rd_wr` = 0 stores `wdata` at `addr`, and a later read of that address returns it.
- R3: An edge with `cs_n` = 1 or `cs` = 0 stores nothing. In flow-through mode, `rvalid` is 0 after such an edge.
- R4: In flow-through mode (`pipe` = 0), after the edge that samples a selected read (`rd_wr` = 1), `rdata` carries the word at the sampled address and `rvalid` = 1 before the next edge.
- R5: In pipelined mode (`pipe` = 1), the word and `rvalid` for a read appear only after the following edge, one cycle later than in flow-through mode.
- R6: `rvalid` is 1 only when the stage feeding the output holds a selected read and `oe_n` = 0. A write cycle therefore gives `rvalid` = 0 at that stage, and `rdata` is 0 whenever `rvalid` is 0.
- R7: `oe_n` acts without a clock. Raising it clears `rvalid` and `rdata` at once, and lowering it restores the pending read output.
- R8: A word written on one port is returned by a read on the other port that is sampled at least one read-port edge after the write edge.
- R9: The two ports run at the same time on unrelated clock phases and in different latency modes without disturbing each other.
- R10: In pipelined mode, the read sampled just before a deselecting edge is still presented after that edge. `rvalid` falls only after the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| l_clk | input | 1 | Left port clock |
| l_rst_n | input | 1 | Left port asynchronous reset, active low |
| l_cs_n | input | 1 | Left select, active low |
| l_cs | input | 1 | Left select, active high |
| l_rd_wr | input | 1 | Left read (1) or write (0) |
| l_oe_n | input | 1 | Left asynchronous output enable, active low |
| l_pipe | input | 1 | Left latency mode: 0 flow-through, 1 pipelined (static) |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left read data, zero when not valid |
| l_rvalid | output | 1 | Left read data drive enable |
| r_clk | input | 1 | Right port clock |
| r_rst_n | input | 1 | Right port asynchronous reset, active low |
| r_cs_n | input | 1 | Right select, active low |
| r_cs | input | 1 | Right select, active high |
| r_rd_wr | input | 1 | Right read (1) or write (0) |
| r_oe_n | input | 1 | Right asynchronous output enable, active low |
| r_pipe | input | 1 | Right latency mode: 0 flow-through, 1 pipelined (static) |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read data, zero when not valid |
| r_rvalid | output | 1 | Right read data drive enable |

## Verification
The bench aims at the latency boundary between modes. A design that delays flow-through data, or forgets the extra stage in pipelined mode, shows data one cycle off and fails every comparison in the stream. It exercises the pipelined tail after a deselect and the write cycle right after a read. A design that tied `rvalid` to the current select state would drop the last word too early or present stale data during a write. Cross-port reads after a write, and deselected writes, expose a design that keeps separate per-port copies or that stores on a deselected edge. A mid-cycle `oe_n` pulse shows whether the enable is wrongly sampled by the clock.

// File: rtl/dpram_pkg.sv
`timescale 1ns/1ps
package dpram_pkg;
  localparam int NUM_PORTS = 2;

  typedef enum logic {
    RD_FLOW = 1'b0,
    RD_PIPE = 1'b1
  } rd_mode_e;

  typedef struct packed {
    logic sel;
    logic rd;
  } stage_ctl_t;
endpackage

// File: rtl/dpram_rst_sync.sv
`timescale 1ns/1ps
module dpram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_d, sync_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/dpram_lvt_core.sv
`timescale 1ns/1ps
module dpram_lvt_core #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk_a,
  input  logic              wen_a,
  input  logic [ADDR_W-1:0] waddr_a,
  input  logic [DATA_W-1:0] wdata_a,
  input  logic [ADDR_W-1:0] raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic              clk_b,
  input  logic              wen_b,
  input  logic [ADDR_W-1:0] waddr_b,
  input  logic [DATA_W-1:0] wdata_b,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_b
);
  localparam int DEPTH = 1 << ADDR_W;

  // One bank per writing port; a tag pair per word tells which bank is newest.
  logic [DATA_W-1:0] bank_a [DEPTH];
  logic [DATA_W-1:0] bank_b [DEPTH];
  logic [DEPTH-1:0]  tag_a, tag_b;

  // Port A marks itself newest by copying the B tag (tags equal).
  always_ff @(posedge clk_a) begin
    if (wen_a) begin
      bank_a[waddr_a] <= wdata_a;
      tag_a[waddr_a]  <= tag_b[waddr_a];
    end
  end

  // Port B marks itself newest by inverting the A tag (tags differ).
  always_ff @(posedge clk_b) begin
    if (wen_b) begin
      bank_b[waddr_b] <= wdata_b;
      tag_b[waddr_b]  <= ~tag_a[waddr_b];
    end
  end

  always_comb begin
    rdata_a = (tag_a[raddr_a] == tag_b[raddr_a]) ? bank_a[raddr_a] : bank_b[raddr_a];
    rdata_b = (tag_a[raddr_b] == tag_b[raddr_b]) ? bank_a[raddr_b] : bank_b[raddr_b];
  end
endmodule

// File: rtl/dpram_port_ctrl.sv
`timescale 1ns/1ps
module dpram_port_ctrl
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              cs_n,
  input  logic              cs,
  input  logic              rd_wr,
  input  logic              oe_n,
  input  logic              pipe_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_wen,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic       rst_n_s;
  rd_mode_e   mode;
  logic       sel_in;
  stage_ctl_t ctl1_d, ctl1_q, ctl2_d, ctl2_q, ctl_out;
  logic              addr_en, pdata_en;
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic [DATA_W-1:0] pdata_d, pdata_q, data_out;

  dpram_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .arst_n (arst_n),
    .srst_n (rst_n_s)
  );

  assign mode = rd_mode_e'(pipe_mode);

  // Next-state logic
  always_comb begin
    sel_in     = ~cs_n & cs;
    ctl1_d.sel = sel_in;
    ctl1_d.rd  = sel_in & rd_wr;
    ctl2_d     = ctl1_q;
    addr_en    = sel_in;
    addr_d     = addr;
    pdata_en   = (mode == RD_PIPE) & ctl1_q.rd;
    pdata_d    = mem_rdata;
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ctl1_q <= '0;
      ctl2_q <= '0;
    end else begin
      ctl1_q <= ctl1_d;
      ctl2_q <= ctl2_d;
    end
  end

  // Datapath registers with explicit clock enables
  always_ff @(posedge clk) begin
    if (addr_en) addr_q <= addr_d;
  end

  always_ff @(posedge clk) begin
    if (pdata_en) pdata_q <= pdata_d;
  end

  // Write goes to the array at the sampling edge
  assign mem_wen   = rst_n_s & sel_in & ~rd_wr;
  assign mem_waddr = addr;
  assign mem_wdata = wdata;
  assign mem_raddr = addr_q;

  // Output stage: one or two control stages, oe_n applied without a clock
  always_comb begin
    if (mode == RD_PIPE) begin
      ctl_out  = ctl2_q;
      data_out = pdata_q;
    end else begin
      ctl_out  = ctl1_q;
      data_out = mem_rdata;
    end
    rvalid = ctl_out.sel & ctl_out.rd & ~oe_n;
    rdata  = rvalid ? data_out : '0;
  end

  // R1: the first edge after reset release sees a quiet output
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rst_n_s) |-> !rvalid);

  // R3: a deselecting edge in flow-through mode leaves the output undriven
  assert_ft_deselect_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mode == RD_FLOW && !sel_in) |=> !rvalid);

  // R6: a flow-through write cycle never presents read data
  assert_write_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mode == RD_FLOW && sel_in && !rd_wr) |=> !rvalid);

  // R10: in pipelined mode the output drops two edges after a deselect
  assert_pipe_tail_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mode == RD_PIPE && !sel_in) |=> ##1 !rvalid);
endmodule

// File: rtl/dpram_dual_clk.sv
`timescale 1ns/1ps
module dpram_dual_clk
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              l_clk,
  input  logic              l_rst_n,
  input  logic              l_cs_n,
  input  logic              l_cs,
  input  logic              l_rd_wr,
  input  logic              l_oe_n,
  input  logic              l_pipe,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_rvalid,
  input  logic              r_clk,
  input  logic              r_rst_n,
  input  logic              r_cs_n,
  input  logic              r_cs,
  input  logic              r_rd_wr,
  input  logic              r_oe_n,
  input  logic              r_pipe,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_rvalid
);
  logic [NUM_PORTS-1:0] clk_v, rst_v, csn_v, cs_v, rw_v, oen_v, pipe_v, wen_v, rvld_v;
  logic [ADDR_W-1:0] addr_v  [NUM_PORTS];
  logic [ADDR_W-1:0] waddr_v [NUM_PORTS];
  logic [ADDR_W-1:0] raddr_v [NUM_PORTS];
  logic [DATA_W-1:0] wdata_v [NUM_PORTS];
  logic [DATA_W-1:0] mwdat_v [NUM_PORTS];
  logic [DATA_W-1:0] mrdat_v [NUM_PORTS];
  logic [DATA_W-1:0] rdata_v [NUM_PORTS];

  assign clk_v  = {r_clk,   l_clk};
  assign rst_v  = {r_rst_n, l_rst_n};
  assign csn_v  = {r_cs_n,  l_cs_n};
  assign cs_v   = {r_cs,    l_cs};
  assign rw_v   = {r_rd_wr, l_rd_wr};
  assign oen_v  = {r_oe_n,  l_oe_n};
  assign pipe_v = {r_pipe,  l_pipe};
  assign addr_v[0]  = l_addr;
  assign addr_v[1]  = r_addr;
  assign wdata_v[0] = l_wdata;
  assign wdata_v[1] = r_wdata;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    dpram_port_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
      .clk       (clk_v[g]),
      .arst_n    (rst_v[g]),
      .cs_n      (csn_v[g]),
      .cs        (cs_v[g]),
      .rd_wr     (rw_v[g]),
      .oe_n      (oen_v[g]),
      .pipe_mode (pipe_v[g]),
      .addr      (addr_v[g]),
      .wdata     (wdata_v[g]),
      .mem_rdata (mrdat_v[g]),
      .mem_wen   (wen_v[g]),
      .mem_waddr (waddr_v[g]),
      .mem_wdata (mwdat_v[g]),
      .mem_raddr (raddr_v[g]),
      .rdata     (rdata_v[g]),
      .rvalid    (rvld_v[g])
    );
  end

  dpram_lvt_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_core (
    .clk_a   (clk_v[0]),
    .wen_a   (wen_v[0]),
    .waddr_a (waddr_v[0]),
    .wdata_a (mwdat_v[0]),
    .raddr_a (raddr_v[0]),
    .rdata_a (mrdat_v[0]),
    .clk_b   (clk_v[1]),
    .wen_b   (wen_v[1]),
    .waddr_b (waddr_v[1]),
    .wdata_b (mwdat_v[1]),
    .raddr_b (raddr_v[1]),
    .rdata_b (mrdat_v[1])
  );

  assign l_rdata  = rdata_v[0];
  assign r_rdata  = rdata_v[1];
  assign l_rvalid = rvld_v[0];
  assign r_rvalid = rvld_v[1];
endmodule

// File: tb/dpram_dual_clk_tb.sv
`timescale 1ns/1ps
module dpram_dual_clk_tb;
  localparam int AW = 10;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic l_clk = 1'b0;
  logic r_clk = 1'b0;
  logic rst_n;
  logic l_cs_n, l_cs, l_rd_wr, l_oe_n, l_pipe, l_rvalid;
  logic r_cs_n, r_cs, r_rd_wr, r_oe_n, r_pipe, r_rvalid;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;

  always #4 l_clk = ~l_clk;
  initial begin
    #2;
    forever #4 r_clk = ~r_clk;
  end

  dpram_dual_clk #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .l_clk(l_clk), .l_rst_n(rst_n), .l_cs_n(l_cs_n), .l_cs(l_cs), .l_rd_wr(l_rd_wr),
    .l_oe_n(l_oe_n), .l_pipe(l_pipe), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .l_rvalid(l_rvalid),
    .r_clk(r_clk), .r_rst_n(rst_n), .r_cs_n(r_cs_n), .r_cs(r_cs), .r_rd_wr(r_rd_wr),
    .r_oe_n(r_oe_n), .r_pipe(r_pipe), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_rdata(r_rdata), .r_rvalid(r_rvalid)
  );

  typedef struct {
    logic          vld;
    logic [DW-1:0] data;
    int            req;
  } exp_t;

  exp_t q_l[$];
  exp_t q_r[$];
  logic [DW-1:0] model [DEPTH];
  bit            pend_rd [2];
  logic [DW-1:0] pend_d  [2];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  function automatic logic [DW-1:0] pat(int a, int s);
    return DW'((a * 37 + s * 11 + 5) & 255);
  endfunction

  task automatic chk(bit ok, int req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Driver: applies one operation and queues the output expected after its edge.
  task automatic op(int p, bit cs_n, bit cs, bit rw, bit oe_n, int a, int d, int req);
    exp_t e;
    bit sel, rd, mode;
    logic [DW-1:0] rv;
    if (p == 0) @(posedge l_clk); else @(posedge r_clk);
    #5;
    if (p == 0) begin
      l_cs_n = cs_n; l_cs = cs; l_rd_wr = rw; l_oe_n = oe_n; l_addr = AW'(a); l_wdata = DW'(d);
      mode = l_pipe;
    end else begin
      r_cs_n = cs_n; r_cs = cs; r_rd_wr = rw; r_oe_n = oe_n; r_addr = AW'(a); r_wdata = DW'(d);
      mode = r_pipe;
    end
    sel = !cs_n && cs;
    rd  = sel && rw;
    if (sel && !rw) model[a] = DW'(d);
    rv = model[a];
    if (!mode) begin
      e.vld  = rd && !oe_n;
      e.data = e.vld ? rv : '0;
    end else begin
      e.vld  = pend_rd[p] && !oe_n;
      e.data = e.vld ? pend_d[p] : '0;
    end
    pend_rd[p] = rd;
    if (rd) pend_d[p] = rv;
    e.req = req;
    if (p == 0) q_l.push_back(e); else q_r.push_back(e);
  endtask

  task automatic wr(int p, int a, int d, int req);
    op(p, 1'b0, 1'b1, 1'b0, 1'b0, a, d, req);
  endtask

  task automatic rd(int p, int a, int req);
    op(p, 1'b0, 1'b1, 1'b1, 1'b0, a, 0, req);
  endtask

  task automatic idle(int p, int req);
    op(p, 1'b1, 1'b1, 1'b1, 1'b0, 0, 0, req);
  endtask

  // Monitors: compare each port's output at the falling edge of its clock.
  always @(negedge l_clk) begin
    exp_t e;
    if (q_l.size() > 0) begin
      e = q_l.pop_front();
      chk(l_rvalid === e.vld, e.req, "left rvalid", int'(l_rvalid), int'(e.vld));
      chk(l_rdata === e.data, e.req, "left rdata", int'(l_rdata), int'(e.data));
    end
  end

  always @(negedge r_clk) begin
    exp_t e;
    if (q_r.size() > 0) begin
      e = q_r.pop_front();
      chk(r_rvalid === e.vld, e.req, "right rvalid", int'(r_rvalid), int'(e.vld));
      chk(r_rdata === e.data, e.req, "right rdata", int'(r_rdata), int'(e.data));
    end
  end

  // R7: a mid-cycle oe_n pulse acts without waiting for a clock edge
  task automatic oe_pulse(int p, logic [DW-1:0] exp_d);
    if (p == 0) begin
      @(posedge l_clk); #1;
      chk(l_rvalid === 1'b1 && l_rdata === exp_d, 7, "left held read", int'(l_rdata), int'(exp_d));
      l_oe_n = 1'b1; #1;
      chk(l_rvalid === 1'b0 && l_rdata === '0, 7, "left oe_n high", int'(l_rvalid), 0);
      l_oe_n = 1'b0; #1;
      chk(l_rvalid === 1'b1 && l_rdata === exp_d, 7, "left oe_n low", int'(l_rdata), int'(exp_d));
    end else begin
      @(posedge r_clk); #1;
      chk(r_rvalid === 1'b1 && r_rdata === exp_d, 7, "right held read", int'(r_rdata), int'(exp_d));
      r_oe_n = 1'b1; #1;
      chk(r_rvalid === 1'b0 && r_rdata === '0, 7, "right oe_n high", int'(r_rvalid), 0);
      r_oe_n = 1'b0; #1;
      chk(r_rvalid === 1'b1 && r_rdata === exp_d, 7, "right oe_n low", int'(r_rdata), int'(exp_d));
    end
  endtask

  task automatic do_reset(bit lp, bit rp);
    rst_n = 1'b0;
    l_cs_n = 1'b1; l_cs = 1'b1; l_rd_wr = 1'b1; l_oe_n = 1'b0; l_addr = '0; l_wdata = '0;
    r_cs_n = 1'b1; r_cs = 1'b1; r_rd_wr = 1'b1; r_oe_n = 1'b0; r_addr = '0; r_wdata = '0;
    l_pipe = lp; r_pipe = rp;
    pend_rd[0] = 1'b0; pend_rd[1] = 1'b0;
    repeat (3) @(posedge l_clk);
    @(negedge l_clk) rst_n = 1'b1;
    repeat (4) @(posedge l_clk);
    // R1: quiet outputs once reset is over
    @(negedge l_clk);
    chk(l_rvalid === 1'b0 && l_rdata === '0, 1, "left after reset", int'(l_rvalid), 0);
    chk(r_rvalid === 1'b0 && r_rdata === '0, 1, "right after reset", int'(r_rvalid), 0);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // Phase A: left flow-through, right pipelined
    do_reset(1'b0, 1'b1);

    // R2: writes from each port
    for (int a = 0; a < 8; a++) wr(0, a, pat(a, 1), 2);
    idle(0, 2);
    for (int a = 8; a < 16; a++) wr(1, a, pat(a, 1), 2);
    idle(1, 2);

    // R4: flow-through reads on the left
    for (int a = 0; a < 8; a++) rd(0, a, 4);
    idle(0, 4);
    // R5: pipelined reads on the right
    for (int a = 8; a < 16; a++) rd(1, a, 5);
    idle(1, 5);
    idle(1, 5);

    // R3: deselected writes store nothing and drive nothing
    op(0, 1'b1, 1'b1, 1'b0, 1'b0, 3, 8'hEE, 3);
    op(0, 1'b0, 1'b0, 1'b0, 1'b0, 4, 8'hEE, 3);
    op(0, 1'b1, 1'b0, 1'b1, 1'b0, 2, 0, 3);
    rd(0, 3, 3);
    rd(0, 4, 3);
    idle(0, 3);

    // R6: oe_n high during a read, and a write right after a read
    op(0, 1'b0, 1'b1, 1'b1, 1'b1, 5, 0, 6);
    rd(0, 5, 6);
    wr(0, 6, 8'h3C, 6);
    rd(0, 6, 6);
    idle(0, 6);
    rd(1, 9, 6);
    wr(1, 10, 8'hC3, 6);
    rd(1, 10, 6);
    idle(1, 6);
    idle(1, 6);

    // R7: asynchronous output enable on both ports
    rd(0, 1, 7);
    oe_pulse(0, model[1]);
    idle(0, 7);
    rd(1, 8, 7);
    rd(1, 8, 7);
    oe_pulse(1, model[8]);
    idle(1, 7);
    idle(1, 7);

    // R8: cross-port visibility in both directions
    wr(0, 20, 8'h5A, 8);
    idle(0, 8);
    rd(1, 20, 8);
    idle(1, 8);
    idle(1, 8);
    wr(1, 21, 8'hA5, 8);
    idle(1, 8);
    rd(0, 21, 8);
    idle(0, 8);

    // R10: pipelined tail after deselect
    rd(1, 12, 10);
    rd(1, 13, 10);
    idle(1, 10);
    idle(1, 10);
    idle(1, 10);

    // R9: both ports busy at the same time
    fork
      begin
        for (int a = 32; a < 40; a++) wr(0, a, pat(a, 2), 9);
        for (int a = 32; a < 40; a++) rd(0, a, 9);
        idle(0, 9);
      end
      begin
        for (int a = 40; a < 48; a++) wr(1, a, pat(a, 3), 9);
        for (int a = 40; a < 48; a++) rd(1, a, 9);
        idle(1, 9);
        idle(1, 9);
      end
    join

    // Phase B: modes swapped; R1 says stored words survive reset
    do_reset(1'b1, 1'b0);
    for (int a = 0; a < 8; a++) rd(0, a, 1);
    idle(0, 5);
    idle(0, 5);
    for (int a = 8; a < 16; a++) rd(1, a, 1);
    idle(1, 4);

    // R10 on the left in pipelined mode
    rd(0, 20, 10);
    idle(0, 10);
    idle(0, 10);

    // R8 with swapped modes
    wr(0, 22, 8'h77, 8);
    idle(0, 8);
    rd(1, 22, 8);
    idle(1, 8);
    wr(1, 23, 8'h88, 8);
    idle(1, 8);
    rd(0, 23, 8);
    idle(0, 8);
    idle(0, 8);

    repeat (4) @(posedge l_clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule